// File: doc/BRIEF.md
# Banked Indirect Configuration Window

This block is the configuration store of a two-channel disk controller, reached by the host through only two addresses. A byte-wide pointer register names one of two channel banks and one of seven entries in that bank. A word-wide data register then reads or writes the named entry. When the pointer's advance flag is set, the entry index steps forward after every data access, so the host can stream through a whole bank with repeated accesses to one address.

Each bank holds two port base addresses, a general configuration byte, two timing bytes, a 10-bit read-ahead count split across two write-only entries, and a read-ahead enable. The stored values leave the block as parallel outputs that feed the channel logic. One bit of the read-ahead control entry is an action bit and not stored state: writing it as one produces a single-cycle FIFO flush pulse.

Host reads are combinational from the current pointer and storage. Writes and pointer updates take effect at the clock edge on which the strobe is sampled.

Top module: `cfg_window_port`

## Requirements
- R1: A write with `host_sel`=1 stores `host_wdata[7:0]` in the pointer. A read with `host_sel`=1 returns the pointer zero-extended to 16 bits. Pointer layout: bit 7 is the advance flag, bit 3 is the bank (0 primary, 1 secondary), and bits 2..0 are the entry index. Bits 6..4 are stored and read back with no other effect.
- R2: A data access (`host_sel`=0) touches only the entry named by the pointer's bank and index. Entry 0 is the command base (16 bits), 1 is the general configuration, 2 is the read-ahead count low byte, 3 is the read-ahead control, 4 is the control base (16 bits), 5 is the data timing and 6 is the command timing.
- R3: After reset the pointer is 0x00. Command base is 0x01F0 on the primary bank and 0x0170 on the secondary. Control base is 0x03F6 on the primary and 0x0376 on the secondary. Data timing is 0xF5 and command timing is 0xDE on both banks. General configuration is 0x01 and read-ahead count and enable are 0.
- R4: With the advance flag set, every data read or write moves the index up by one, from 6 (or 7) back to 0. The bank bit never changes. The new index applies from the next access.
- R5: With the advance flag clear, data accesses leave the pointer unchanged.
- R6: General configuration bit 7 drives `dma_en_o`, bit 6 drives `drv_rst_o`, bit 3 drives `irq_low_o` (interrupt active low) and bit 0 drives `io_en_o`, each per bank.
- R7: The read-ahead count takes bits 7..0 from a write to entry 2 and bits 9..8 from `host_wdata[1:0]` of a write to entry 3. Each write leaves the other part unchanged.
- R8: Reads of entries 2, 3 and 7 return zero. Writes to entry 7 change no output.
- R9: A write to entry 3 with bit 6 set makes that bank's `fifo_clr_o` high for exactly the one cycle after the write edge. Bit 7 of the same write sets `ra_en_o`.
- R10: Byte entries (1, 5, 6) store `host_wdata[7:0]` and read back zero-extended. Word entries (0, 4) store and return all 16 bits.
- R11: The host never asserts `host_wr` and `host_rd` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 1 selects the pointer, 0 the data register |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the current selection |
| cmd_base_o | output | 32 | Command base per bank, bank b at [16b+15:16b] |
| ctl_base_o | output | 32 | Control base per bank |
| gen_cfg_o | output | 16 | General configuration byte per bank |
| dma_en_o | output | 2 | DMA enable per bank |
| drv_rst_o | output | 2 | Drive reset per bank |
| irq_low_o | output | 2 | Interrupt active-low select per bank |
| io_en_o | output | 2 | Port decode enable per bank |
| data_tim_o | output | 16 | Data timing byte per bank |
| cmd_tim_o | output | 16 | Command timing byte per bank |
| ra_count_o | output | 20 | 10-bit read-ahead count per bank |
| ra_en_o | output | 2 | Read-ahead enable per bank |
| fifo_clr_o | output | 2 | One-cycle FIFO flush pulse per bank |

## Verification
The assertions take for granted that a read and a write never share a cycle (R11). One check guards that input rule. The advance and pulse properties rely on each strobe being a single sampled cycle. The bench drives every strobe for exactly one cycle from a single task that raises either the write or the read, never both. The random mix of pointer values, including index 7 and both bank settings, therefore stays within that rule while covering wrap-around and write-only entries.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

    localparam int unsigned IDX_W    = 3;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned RA_W     = 10;

    localparam logic [IDX_W-1:0] IDX_CMD_BASE = 3'd0;
    localparam logic [IDX_W-1:0] IDX_GEN_CFG  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_RA_LO    = 3'd2;
    localparam logic [IDX_W-1:0] IDX_RA_CTL   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_CTL_BASE = 3'd4;
    localparam logic [IDX_W-1:0] IDX_DATA_TIM = 3'd5;
    localparam logic [IDX_W-1:0] IDX_CMD_TIM  = 3'd6;
    localparam logic [IDX_W-1:0] IDX_LAST     = IDX_CMD_TIM;

    typedef struct packed {
        logic             adv;
        logic [2:0]       spare;
        logic             bank;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    typedef struct packed {
        logic [WORD_W-1:0] cmd_base;
        logic [WORD_W-1:0] ctl_base;
        logic [BYTE_W-1:0] gen_cfg;
        logic [BYTE_W-1:0] data_tim;
        logic [BYTE_W-1:0] cmd_tim;
        logic [RA_W-1:0]   ra_cnt;
        logic              ra_en;
        logic              fifo_clr;
    } bank_t;

endpackage

// File: rtl/cfg_ptr_reg.sv
module cfg_ptr_reg
    import cfg_window_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic              data_acc,
    input  logic [BYTE_W-1:0] wdata,
    output ptr_t              ptr_o
);

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (ptr_wr) begin
            ptr_d = ptr_t'(wdata);
        end else if (data_acc && ptr_q.adv) begin
            if (ptr_q.idx >= IDX_LAST) ptr_d.idx = '0;
            else                       ptr_d.idx = ptr_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ptr_wr && ptr_q.adv && ptr_q.idx == IDX_LAST) |=> (ptr_q.idx == '0));

    // R4
    ptr_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ptr_wr) |=> $stable(ptr_q.bank));

    // R5
    ptr_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ptr_wr && !ptr_q.adv) |=> $stable(ptr_q));

endmodule

// File: rtl/cfg_bank_regs.sv
module cfg_bank_regs
    import cfg_window_pkg::*;
#(
    parameter logic [WORD_W-1:0] CMD_BASE_RST = 16'h01F0,
    parameter logic [WORD_W-1:0] CTL_BASE_RST = 16'h03F6,
    parameter logic [BYTE_W-1:0] GEN_CFG_RST  = 8'h01,
    parameter logic [BYTE_W-1:0] DATA_TIM_RST = 8'hF5,
    parameter logic [BYTE_W-1:0] CMD_TIM_RST  = 8'hDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output bank_t             bank_o
);

    localparam int unsigned RA_HI_W = RA_W - BYTE_W;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d          = bank_q;
        bank_d.fifo_clr = 1'b0;
        if (wr_en) begin
            case (idx)
                IDX_CMD_BASE: bank_d.cmd_base = wdata;
                IDX_GEN_CFG:  bank_d.gen_cfg  = wdata[BYTE_W-1:0];
                IDX_RA_LO:    bank_d.ra_cnt[BYTE_W-1:0] = wdata[BYTE_W-1:0];
                IDX_RA_CTL: begin
                    bank_d.ra_cnt[RA_W-1:BYTE_W] = wdata[RA_HI_W-1:0];
                    bank_d.ra_en    = wdata[7];
                    bank_d.fifo_clr = wdata[6];
                end
                IDX_CTL_BASE: bank_d.ctl_base = wdata;
                IDX_DATA_TIM: bank_d.data_tim = wdata[BYTE_W-1:0];
                IDX_CMD_TIM:  bank_d.cmd_tim  = wdata[BYTE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.cmd_base <= CMD_BASE_RST;
            bank_q.ctl_base <= CTL_BASE_RST;
            bank_q.gen_cfg  <= GEN_CFG_RST;
            bank_q.data_tim <= DATA_TIM_RST;
            bank_q.cmd_tim  <= CMD_TIM_RST;
            bank_q.ra_cnt   <= '0;
            bank_q.ra_en    <= 1'b0;
            bank_q.fifo_clr <= 1'b0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank_o = bank_q;

    // R9
    fifo_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q.fifo_clr |-> $past(wr_en && idx == IDX_RA_CTL && wdata[6]));

    // R8
    idx7_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 3'd7) |=> $stable({bank_q.cmd_base, bank_q.ctl_base, bank_q.gen_cfg,
            bank_q.data_tim, bank_q.cmd_tim, bank_q.ra_cnt, bank_q.ra_en}));

    // R7
    ra_lo_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_RA_LO) |=>
            (bank_q.ra_cnt[RA_W-1:BYTE_W] == $past(bank_q.ra_cnt[RA_W-1:BYTE_W]))
            && (bank_q.ra_cnt[BYTE_W-1:0] == $past(wdata[BYTE_W-1:0])));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_window_pkg::*;
#(
    parameter int unsigned NBANK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_ptr,
    input  ptr_t              ptr,
    input  bank_t             banks [NBANK],
    output logic [WORD_W-1:0] rdata
);

    bank_t cur;

    always_comb begin
        cur   = banks[ptr.bank];
        rdata = '0;
        if (sel_ptr) begin
            rdata = {{(WORD_W-BYTE_W){1'b0}}, ptr};
        end else begin
            case (ptr.idx)
                IDX_CMD_BASE: rdata = cur.cmd_base;
                IDX_GEN_CFG:  rdata = {{(WORD_W-BYTE_W){1'b0}}, cur.gen_cfg};
                IDX_CTL_BASE: rdata = cur.ctl_base;
                IDX_DATA_TIM: rdata = {{(WORD_W-BYTE_W){1'b0}}, cur.data_tim};
                IDX_CMD_TIM:  rdata = {{(WORD_W-BYTE_W){1'b0}}, cur.cmd_tim};
                default:      rdata = '0;
            endcase
        end
    end

    // R8
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ptr && (ptr.idx == IDX_RA_LO || ptr.idx == IDX_RA_CTL || ptr.idx == 3'd7))
            |-> (rdata == '0));

    // R1
    ptr_read_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ptr |-> (rdata[WORD_W-1:BYTE_W] == '0));

endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port
    import cfg_window_pkg::*;
#(
    parameter logic [15:0] PRI_CMD_BASE = 16'h01F0,
    parameter logic [15:0] SEC_CMD_BASE = 16'h0170,
    parameter logic [15:0] PRI_CTL_BASE = 16'h03F6,
    parameter logic [15:0] SEC_CTL_BASE = 16'h0376,
    parameter logic [7:0]  GEN_CFG_RST  = 8'h01,
    parameter logic [7:0]  DATA_TIM_RST = 8'hF5,
    parameter logic [7:0]  CMD_TIM_RST  = 8'hDE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic [31:0] cmd_base_o,
    output logic [31:0] ctl_base_o,
    output logic [15:0] gen_cfg_o,
    output logic [1:0]  dma_en_o,
    output logic [1:0]  drv_rst_o,
    output logic [1:0]  irq_low_o,
    output logic [1:0]  io_en_o,
    output logic [15:0] data_tim_o,
    output logic [15:0] cmd_tim_o,
    output logic [19:0] ra_count_o,
    output logic [1:0]  ra_en_o,
    output logic [1:0]  fifo_clr_o
);

    localparam int unsigned NBANK = 2;

    ptr_t  ptr;
    bank_t banks [NBANK];
    logic  ptr_wr, data_acc, data_wr;

    assign ptr_wr   = host_sel && host_wr;
    assign data_wr  = !host_sel && host_wr;
    assign data_acc = !host_sel && (host_wr || host_rd);

    cfg_ptr_reg u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_wr   (ptr_wr),
        .data_acc (data_acc),
        .wdata    (host_wdata[BYTE_W-1:0]),
        .ptr_o    (ptr)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        cfg_bank_regs #(
            .CMD_BASE_RST (b == 0 ? PRI_CMD_BASE : SEC_CMD_BASE),
            .CTL_BASE_RST (b == 0 ? PRI_CTL_BASE : SEC_CTL_BASE),
            .GEN_CFG_RST  (GEN_CFG_RST),
            .DATA_TIM_RST (DATA_TIM_RST),
            .CMD_TIM_RST  (CMD_TIM_RST)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (data_wr && (ptr.bank == 1'(b))),
            .idx    (ptr.idx),
            .wdata  (host_wdata),
            .bank_o (banks[b])
        );

        assign cmd_base_o[b*WORD_W +: WORD_W] = banks[b].cmd_base;
        assign ctl_base_o[b*WORD_W +: WORD_W] = banks[b].ctl_base;
        assign gen_cfg_o[b*BYTE_W +: BYTE_W]  = banks[b].gen_cfg;
        assign data_tim_o[b*BYTE_W +: BYTE_W] = banks[b].data_tim;
        assign cmd_tim_o[b*BYTE_W +: BYTE_W]  = banks[b].cmd_tim;
        assign ra_count_o[b*RA_W +: RA_W]     = banks[b].ra_cnt;
        assign ra_en_o[b]    = banks[b].ra_en;
        assign fifo_clr_o[b] = banks[b].fifo_clr;
        assign dma_en_o[b]   = banks[b].gen_cfg[7];
        assign drv_rst_o[b]  = banks[b].gen_cfg[6];
        assign irq_low_o[b]  = banks[b].gen_cfg[3];
        assign io_en_o[b]    = banks[b].gen_cfg[0];
    end

    cfg_read_mux #(.NBANK(NBANK)) u_rmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_ptr (host_sel),
        .ptr     (ptr),
        .banks   (banks),
        .rdata   (host_rdata)
    );

    // R11
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));

    // R9
    fifo_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_clr_o && !(data_wr && ptr.idx == IDX_RA_CTL)) |=> (fifo_clr_o == 2'b00));

endmodule

// File: tb/cfg_window_port_bench.sv
`timescale 1ns/1ps
module cfg_window_port_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_sel, host_wr, host_rd;
    logic [15:0] host_wdata, host_rdata;
    logic [31:0] cmd_base_o, ctl_base_o;
    logic [15:0] gen_cfg_o, data_tim_o, cmd_tim_o;
    logic [1:0]  dma_en_o, drv_rst_o, irq_low_o, io_en_o, ra_en_o, fifo_clr_o;
    logic [19:0] ra_count_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    cfg_window_port u_cfg_window_port (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_base_o(cmd_base_o), .ctl_base_o(ctl_base_o), .gen_cfg_o(gen_cfg_o),
        .dma_en_o(dma_en_o), .drv_rst_o(drv_rst_o), .irq_low_o(irq_low_o),
        .io_en_o(io_en_o), .data_tim_o(data_tim_o), .cmd_tim_o(cmd_tim_o),
        .ra_count_o(ra_count_o), .ra_en_o(ra_en_o), .fifo_clr_o(fifo_clr_o)
    );

    // reference model
    logic [7:0]  m_ptr;
    logic [15:0] m_cmd [2];
    logic [15:0] m_ctl [2];
    logic [7:0]  m_gen [2];
    logic [7:0]  m_dt  [2];
    logic [7:0]  m_ct  [2];
    logic [9:0]  m_ra  [2];
    logic        m_rae [2];
    logic        m_fc  [2];

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req,
                       input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic sel);
        int b;
        b = int'(m_ptr[3]);
        if (sel) return {8'h00, m_ptr};
        case (m_ptr[2:0])
            3'd0: return m_cmd[b];
            3'd1: return {8'h00, m_gen[b]};
            3'd4: return m_ctl[b];
            3'd5: return {8'h00, m_dt[b]};
            3'd6: return {8'h00, m_ct[b]};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_reset();
        m_ptr = 8'h00;
        m_cmd[0] = 16'h01F0; m_cmd[1] = 16'h0170;
        m_ctl[0] = 16'h03F6; m_ctl[1] = 16'h0376;
        for (int b = 0; b < 2; b++) begin
            m_gen[b] = 8'h01; m_dt[b] = 8'hF5; m_ct[b] = 8'hDE;
            m_ra[b] = '0; m_rae[b] = 1'b0; m_fc[b] = 1'b0;
        end
    endtask

    task automatic model_step(input logic sel, input logic wr, input logic rd,
                              input logic [15:0] wd);
        int b;
        b = int'(m_ptr[3]);
        m_fc[0] = 1'b0; m_fc[1] = 1'b0;
        if (sel) begin
            if (wr) m_ptr = wd[7:0];
        end else if (wr || rd) begin
            if (wr) begin
                case (m_ptr[2:0])
                    3'd0: m_cmd[b] = wd;
                    3'd1: m_gen[b] = wd[7:0];
                    3'd2: m_ra[b][7:0] = wd[7:0];
                    3'd3: begin m_ra[b][9:8] = wd[1:0]; m_rae[b] = wd[7]; m_fc[b] = wd[6]; end
                    3'd4: m_ctl[b] = wd;
                    3'd5: m_dt[b] = wd[7:0];
                    3'd6: m_ct[b] = wd[7:0];
                    default: ;
                endcase
            end
            if (m_ptr[7]) m_ptr[2:0] = (m_ptr[2:0] >= 3'd6) ? 3'd0 : m_ptr[2:0] + 3'd1;
        end
    endtask

    task automatic check_outputs(input string tag);
        chk(cmd_base_o, {m_cmd[1], m_cmd[0]}, "R2", {tag, " cmd_base"});
        chk(ctl_base_o, {m_ctl[1], m_ctl[0]}, "R2", {tag, " ctl_base"});
        chk(gen_cfg_o, {m_gen[1], m_gen[0]}, "R10", {tag, " gen_cfg"});
        chk({dma_en_o, drv_rst_o, irq_low_o, io_en_o},
            {m_gen[1][7], m_gen[0][7], m_gen[1][6], m_gen[0][6],
             m_gen[1][3], m_gen[0][3], m_gen[1][0], m_gen[0][0]}, "R6", {tag, " decoded cfg"});
        chk({data_tim_o, cmd_tim_o}, {m_dt[1], m_dt[0], m_ct[1], m_ct[0]}, "R10",
            {tag, " timing"});
        chk(ra_count_o, {m_ra[1], m_ra[0]}, "R7", {tag, " ra_count"});
        chk(ra_en_o, {m_rae[1], m_rae[0]}, "R9", {tag, " ra_en"});
        chk(fifo_clr_o, {m_fc[1], m_fc[0]}, "R9", {tag, " fifo_clr pulse"});
    endtask

    // one host cycle; read data checked before the edge, outputs after it
    task automatic op(input logic sel, input logic wr, input logic rd,
                      input logic [15:0] wd, input string tag);
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = wd;
        #1;
        if (rd) chk(host_rdata, exp_read(sel), tag, "read data");
        @(posedge clk);
        #1;
        host_wr = 1'b0; host_rd = 1'b0;
        model_step(sel, wr, rd, wd);
        check_outputs(tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd4242);
        host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R3 reset outputs
        check_outputs("R3 reset");
        op(1'b1, 1'b0, 1'b1, 16'h0, "R3 ptr reset");
        // R4 walk primary bank with advance, wrap past 6; R8 zero on 2,3
        op(1'b1, 1'b1, 1'b0, 16'h0080, "R1 ptr write");
        for (int i = 0; i < 8; i++) op(1'b0, 1'b0, 1'b1, 16'h0, "R4 walk primary");
        op(1'b1, 1'b0, 1'b1, 16'h0, "R4 index after wrap");
        // secondary bank walk, R3 values
        op(1'b1, 1'b1, 1'b0, 16'h0088, "R1 ptr secondary");
        for (int i = 0; i < 7; i++) op(1'b0, 1'b0, 1'b1, 16'h0, "R3 walk secondary");
        op(1'b1, 1'b0, 1'b1, 16'h0, "R4 bank kept");
        // R1 spare bits stored
        op(1'b1, 1'b1, 1'b0, 16'hFF71, "R1 spare bits");
        op(1'b1, 1'b0, 1'b1, 16'h0, "R1 readback");
        // R6 / R10 general config on secondary idx1, no advance (bit7=0)
        op(1'b1, 1'b1, 1'b0, 16'h0009, "R5 ptr no adv");
        op(1'b0, 1'b1, 1'b0, 16'h55C8, "R6 gen write");
        op(1'b0, 1'b0, 1'b1, 16'h0, "R10 gen readback");
        op(1'b0, 1'b0, 1'b1, 16'h0, "R5 same index");
        // R10 word and byte entries
        op(1'b1, 1'b1, 1'b0, 16'h0084, "R1 ptr ctl base");
        op(1'b0, 1'b1, 1'b0, 16'hBEEF, "R10 word write");
        op(1'b0, 1'b1, 1'b0, 16'hABCD, "R10 byte write");
        op(1'b1, 1'b1, 1'b0, 16'h0084, "R1 ptr ctl base again");
        op(1'b0, 1'b0, 1'b1, 16'h0, "R10 word read");
        op(1'b0, 1'b0, 1'b1, 16'h0, "R10 byte read");
        // R7 split count, R9 pulse and enable
        op(1'b1, 1'b1, 1'b0, 16'h0082, "R1 ptr ra");
        op(1'b0, 1'b1, 1'b0, 16'h773C, "R7 low byte");
        op(1'b0, 1'b1, 1'b0, 16'h0002, "R7 high bits");
        op(1'b1, 1'b1, 1'b0, 16'h0003, "R1 ptr ractl");
        op(1'b0, 1'b1, 1'b0, 16'h00C1, "R9 flush and enable");
        op(1'b0, 1'b0, 1'b1, 16'h0, "R9 pulse ends, reads zero");
        op(1'b0, 1'b1, 1'b0, 16'h0040, "R9 flush again");
        op(1'b0, 1'b1, 1'b0, 16'h0040, "R9 back to back");
        op(1'b0, 1'b0, 1'b0, 16'h0, "R9 idle after pulse");
        // R8 entry 7 ignored
        op(1'b1, 1'b1, 1'b0, 16'h0007, "R1 ptr idx7");
        op(1'b0, 1'b1, 1'b0, 16'hFFFF, "R8 idx7 write");
        op(1'b0, 1'b0, 1'b1, 16'h0, "R8 idx7 read");
        op(1'b1, 1'b1, 1'b0, 16'h008F, "R1 ptr idx7 adv");
        op(1'b0, 1'b1, 1'b0, 16'h1234, "R4 idx7 wraps");
        op(1'b1, 1'b0, 1'b1, 16'h0, "R4 after idx7");
        // random mix (R2, R11 respected: never read and write together)
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            logic sel, wr;
            r   = $urandom;
            sel = (r[1:0] == 2'b00);
            wr  = r[2];
            op(sel, wr, !wr, r[31:16], "R2 random");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule